// File: doc/BRIEF.md
# Variable-Latency Adder with Latency Predictor

This block is one pipelined adder stage in which nearly every addition finishes in a single clock cycle. Only the rare operand pattern that drives the full-length carry ripple is given a second cycle. A decoder looks at the operands and the carry-in as they are offered and predicts which latency the operation needs before the adder evaluates it. For a predicted two-cycle operation, the stage holds its accept signal low for one cycle, which freezes the stage upstream. The result-valid strobe then comes one cycle later than usual. The sum and carry-out are registered, and their values do not depend on the latency chosen.

Operands arrive on a valid/ready handshake. Results leave on a valid strobe with no back-pressure.

A self-test mode drives the adder from an internal 16-bit maximal-length LFSR instead of the input ports. A comparator checks each result against an independently computed reference sum. Any mismatch sets a sticky error flag, and only reset clears it.

Top module: `var_lat_adder`

## Requirements
- R1: An operation is treated as critical, and takes two cycles, exactly when every bit of a XOR b is 1 and the carry-in is 1. Every other operation takes one cycle.
- R2: A one-cycle operation is accepted at a rising edge where in_valid_i and in_ready_o are both high. out_valid_o is then high for the following cycle, with {cout_o, sum_o} equal to a + b + cin as a (WIDTH+1)-bit value.
- R3: A critical operation gives in_ready_o low for exactly the one cycle after it is accepted, with out_valid_o low in that cycle. The correct {cout_o, sum_o} follows with out_valid_o high in the cycle after that.
- R4: While in_ready_o is low, in_valid_i and the operand inputs are ignored: no operation is accepted and no extra result appears.
- R5: After reset, out_valid_o is 0, in_ready_o is 1, sum_o and cout_o are 0, and test_err_o is 0.
- R6: While test_mode_i is high, in_valid_i and the operand inputs are ignored, and an operation is accepted at every edge where in_ready_o is high. The operands come from the LFSR state L: a bit i = L[i mod 16], b bit i = L[(i+7) mod 16], and cin = L[0]. L resets to 16'hACE1 and steps only on an accepted test operation, as L <= {L[14:0], parity(L & 16'hB400)}.
- R7: test_err_o is set when a test-mode result differs from the reference sum, and it stays set until reset. With a correct adder it stays 0.
- R8: out_valid_o is low in every cycle that does not carry a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Operand offer |
| in_ready_o | output | 1 | Stage can accept an operand |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| cin_i | input | 1 | Carry-in |
| test_mode_i | input | 1 | Select LFSR-driven self-test |
| out_valid_o | output | 1 | Result strobe |
| sum_o | output | WIDTH | Registered sum |
| cout_o | output | 1 | Registered carry-out |
| test_err_o | output | 1 | Sticky self-test mismatch flag |

## Verification
The assertions assume that test_mode_i changes only while no critical operation is in flight. A mode change in the middle of a stall would switch the operand source, and the accept rules do not cover that case. The bench changes test_mode_i only at a falling edge on an idle cycle, after the last result has been seen. Outside test mode, the handshake assertions assume nothing about in_valid_i. The bench therefore deliberately offers new operands during stall cycles to show that they are refused. Random operands are biased so that about a quarter of them are full-propagate patterns, which keeps the two-cycle path well covered.

// File: rtl/vla_pkg.sv
package vla_pkg;
  localparam int unsigned LFSR_W    = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;  // x^16+x^14+x^13+x^11+1
  localparam int unsigned B_ROT     = 7;

  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], ^(s & LFSR_TAPS)};
  endfunction
endpackage

// File: rtl/vla_adder_core.sv
module vla_adder_core #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH:0] c;
  assign c[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic p, g;
    assign p        = a_i[i] ^ b_i[i];
    assign g        = a_i[i] & b_i[i];
    assign sum_o[i] = p ^ c[i];
    assign c[i+1]   = g | (p & c[i]);
  end

  assign cout_o = c[WIDTH];
endmodule

// File: rtl/vla_lat_predictor.sv
module vla_lat_predictor #(
  parameter int unsigned WIDTH    = 32,
  parameter int unsigned GROUP    = 4,
  parameter bit          TOP_PRED = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic             crit_o
);
  localparam int unsigned LOW_W = WIDTH - GROUP;

  logic [WIDTH-1:0] prop;
  assign prop = a_i ^ b_i;

  if (TOP_PRED && (WIDTH > GROUP)) begin : g_top_group
    // top group fully propagating with a carry arriving from below
    logic [LOW_W:0] low_sum;
    assign low_sum = {1'b0, a_i[LOW_W-1:0]} + {1'b0, b_i[LOW_W-1:0]}
                   + {{LOW_W{1'b0}}, cin_i};
    assign crit_o  = (&prop[WIDTH-1:LOW_W]) & low_sum[LOW_W];
  end else begin : g_full
    assign crit_o = (&prop) & cin_i;
  end
endmodule

// File: rtl/vla_lfsr.sv
module vla_lfsr import vla_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  output logic [LFSR_W-1:0] state_o
);
  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= LFSR_SEED;
    else if (step_i) state_q <= lfsr_next(state_q);
  end

  assign state_o = state_q;

  a_r6_lfsr_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  a_r6_lfsr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(state_q));
endmodule

// File: rtl/vla_selftest.sv
module vla_selftest #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic             test_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic             res_valid_i,
  input  logic [WIDTH-1:0] res_sum_i,
  input  logic             res_cout_i,
  output logic             err_o
);
  logic [WIDTH:0] ref_d, ref_q;
  logic           tag_q, err_q;

  assign ref_d = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= '0;
      tag_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (issue_i) begin
        ref_q <= ref_d;
        tag_q <= test_i;
      end
      if (res_valid_i && tag_q && ({res_cout_i, res_sum_i} != ref_q))
        err_q <= 1'b1;
    end
  end

  assign err_o = err_q;

  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
endmodule

// File: rtl/var_lat_adder.sv
module var_lat_adder import vla_pkg::*; #(
  parameter int unsigned WIDTH    = 32,
  parameter int unsigned GROUP    = 4,
  parameter bit          TOP_PRED = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic             test_mode_i,
  output logic             out_valid_o,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             test_err_o
);
  logic [LFSR_W-1:0] lfsr;
  logic [WIDTH-1:0]  tm_a, tm_b;
  logic [WIDTH-1:0]  src_a, src_b, core_a, core_b, core_sum;
  logic              src_c, core_c, core_cout, crit, issue;

  logic              hold_q, vld_q, cout_q;
  logic [WIDTH-1:0]  opa_q, opb_q, sum_q;
  logic              opc_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_tm
    assign tm_a[i] = lfsr[i % LFSR_W];
    assign tm_b[i] = lfsr[(i + B_ROT) % LFSR_W];
  end

  assign src_a = test_mode_i ? tm_a    : a_i;
  assign src_b = test_mode_i ? tm_b    : b_i;
  assign src_c = test_mode_i ? lfsr[0] : cin_i;

  assign in_ready_o = !hold_q;
  assign issue      = in_ready_o && (test_mode_i || in_valid_i);

  vla_lfsr u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (issue && test_mode_i),
    .state_o (lfsr)
  );

  vla_lat_predictor #(.WIDTH(WIDTH), .GROUP(GROUP), .TOP_PRED(TOP_PRED)) u_pred (
    .a_i    (src_a),
    .b_i    (src_b),
    .cin_i  (src_c),
    .crit_o (crit)
  );

  // second cycle of a stretched op evaluates the captured operands
  assign core_a = hold_q ? opa_q : src_a;
  assign core_b = hold_q ? opb_q : src_b;
  assign core_c = hold_q ? opc_q : src_c;

  vla_adder_core #(.WIDTH(WIDTH)) u_core (
    .a_i    (core_a),
    .b_i    (core_b),
    .cin_i  (core_c),
    .sum_o  (core_sum),
    .cout_o (core_cout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      vld_q  <= 1'b0;
      sum_q  <= '0;
      cout_q <= 1'b0;
      opa_q  <= '0;
      opb_q  <= '0;
      opc_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (hold_q) begin
        hold_q <= 1'b0;
        sum_q  <= core_sum;
        cout_q <= core_cout;
        vld_q  <= 1'b1;
      end else if (issue) begin
        if (crit) begin
          hold_q <= 1'b1;
          opa_q  <= src_a;
          opb_q  <= src_b;
          opc_q  <= src_c;
        end else begin
          sum_q  <= core_sum;
          cout_q <= core_cout;
          vld_q  <= 1'b1;
        end
      end
    end
  end

  vla_selftest #(.WIDTH(WIDTH)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (issue),
    .test_i      (test_mode_i),
    .a_i         (src_a),
    .b_i         (src_b),
    .cin_i       (src_c),
    .res_valid_i (vld_q),
    .res_sum_i   (sum_q),
    .res_cout_i  (cout_q),
    .err_o       (test_err_o)
  );

  assign out_valid_o = vld_q;
  assign sum_o       = sum_q;
  assign cout_o      = cout_q;

  a_r3_stall_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |=> in_ready_o);
  a_r3_crit_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && crit) |=> (!in_ready_o && !out_valid_o));
  a_r3_stall_then_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |=> out_valid_o);
  a_r2_fast_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && !crit) |=> (out_valid_o && in_ready_o));
  a_r8_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && !issue) |=> !out_valid_o);
  if (!TOP_PRED) begin : g_r1_chk
    a_r1_crit_needs_cin: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (issue && crit) |-> src_c);
  end
endmodule

// File: tb/var_lat_adder_tb_top.sv
module var_lat_adder_tb_top;
  localparam int unsigned W       = 32;
  localparam time         CLK_PER = 10ns;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic         in_ready_o;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic         cin_i = 1'b0;
  logic         test_mode_i = 1'b0;
  logic         out_valid_o;
  logic [W-1:0] sum_o;
  logic         cout_o;
  logic         test_err_o;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;
  bit          done  = 1'b0;

  always #(CLK_PER/2) clk_i = ~clk_i;

  var_lat_adder #(.WIDTH(W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .test_mode_i(test_mode_i),
    .out_valid_o(out_valid_o), .sum_o(sum_o), .cout_o(cout_o), .test_err_o(test_err_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_crit(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    return ((a ^ b) == {W{1'b1}}) && c;
  endfunction

  function automatic logic [W:0] exp_sum(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
  endfunction

  function automatic logic [15:0] m_step(input logic [15:0] s);
    return {s[14:0], ^(s & 16'hB400)};
  endfunction

  // one operation through the port; optionally offer junk during a stall
  task automatic do_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic c, input bit junk);
    logic [W:0] e;
    e = exp_sum(a, b, c);
    @(negedge clk_i);
    a_i = a; b_i = b; cin_i = c; in_valid_i = 1'b1;
    @(posedge clk_i); #1;
    if (!exp_crit(a, b, c)) begin
      chk("R1/R2 one-cycle valid", 64'(out_valid_o), 64'd1);
      chk("R2 sum", 64'({cout_o, sum_o}), 64'(e));
      chk("R2 ready stays high", 64'(in_ready_o), 64'd1);
    end else begin
      chk("R1/R3 stall ready low", 64'(in_ready_o), 64'd0);
      chk("R3 no early valid", 64'(out_valid_o), 64'd0);
      @(negedge clk_i);
      if (junk) begin
        a_i = ~a; b_i = a; cin_i = 1'b0; in_valid_i = 1'b1;
      end else in_valid_i = 1'b0;
      @(posedge clk_i); #1;
      chk("R3 stretched valid", 64'(out_valid_o), 64'd1);
      chk("R3 stretched sum", 64'({cout_o, sum_o}), 64'(e));
      chk("R3 ready back", 64'(in_ready_o), 64'd1);
      if (junk) begin
        @(negedge clk_i); in_valid_i = 1'b0;
        @(posedge clk_i); #1;
        chk("R4 stall offer ignored", 64'(out_valid_o), 64'd0);
      end
    end
  endtask

  task automatic idle_check();
    @(negedge clk_i); in_valid_i = 1'b0;
    @(posedge clk_i); #1;
    chk("R8 idle no valid", 64'(out_valid_o), 64'd0);
  endtask

  initial begin : watchdog
    #(CLK_PER * 150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] m;
    void'($urandom(32'd20240611));
    #(CLK_PER * 3);
    @(negedge clk_i); rst_ni = 1'b1;
    #1;
    chk("R5 reset valid", 64'(out_valid_o), 64'd0);
    chk("R5 reset ready", 64'(in_ready_o), 64'd1);
    chk("R5 reset sum", 64'({cout_o, sum_o}), 64'd0);
    chk("R5 reset err", 64'(test_err_o), 64'd0);

    // directed corners
    do_op('0, '0, 1'b0, 1'b0);
    do_op({W{1'b1}}, '0, 1'b1, 1'b1);              // R1 critical, wraps to 0 carry 1
    do_op({W{1'b1}}, '0, 1'b0, 1'b0);              // R1 all-propagate, no cin
    do_op({W/2{2'b01}}, {W/2{2'b10}}, 1'b1, 1'b1); // R1 critical alternating
    do_op({{(W-1){1'b1}}, 1'b0}, '0, 1'b1, 1'b0);  // R1 one propagate bit missing
    do_op({W{1'b1}}, {W{1'b1}}, 1'b1, 1'b0);
    idle_check();

    // constrained random, back-to-back
    for (int k = 0; k < 400; k++) begin
      logic [W-1:0] ra, rb;
      logic rc;
      ra = $urandom();
      rb = ($urandom_range(3) == 0) ? ~ra : W'($urandom());
      rc = 1'($urandom());
      do_op(ra, rb, rc, 1'($urandom()));
      if (k % 50 == 0) idle_check();
    end
    idle_check();

    // R6 test mode from reset-seeded LFSR, in_valid held low
    m = 16'hACE1;
    @(negedge clk_i); test_mode_i = 1'b1; in_valid_i = 1'b0;
    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] ta, tb;
      logic tc;
      for (int i = 0; i < W; i++) begin
        ta[i] = m[i % 16];
        tb[i] = m[(i + 7) % 16];
      end
      tc = m[0];
      @(posedge clk_i); #1;
      if (exp_crit(ta, tb, tc)) begin
        chk("R6 test stall", 64'(in_ready_o), 64'd0);
        @(posedge clk_i); #1;
      end
      chk("R6 test valid", 64'(out_valid_o), 64'd1);
      chk("R6 test sum", 64'({cout_o, sum_o}), 64'(exp_sum(ta, tb, tc)));
      m = m_step(m);
    end
    @(negedge clk_i); test_mode_i = 1'b0;
    @(posedge clk_i); #1;
    chk("R6 test off no valid", 64'(out_valid_o), 64'd0);
    chk("R7 err clear on good adder", 64'(test_err_o), 64'd0);

    do_op(32'h1234_5678, 32'h0FED_CBA9, 1'b1, 1'b0);
    idle_check();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule